// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a set of external interrupt lines and turns activity on them into interrupt requests for a processor. Every line first crosses into the controller clock domain through a small synchroniser. A per-line detector then works on the synchronised sample, in one of five modes chosen by software: low level, high level, rising edge, falling edge, or either edge. A detection sets the line's detect flag. Each line has its own interrupt output, which is the detect flag gated by the line's enable.

Software reaches the block over a plain 32-bit register port with separate read and write strobes. Enables are turned on and off through two registers that take a mask of ones, so no read-modify-write is needed. Latched edge detections are acknowledged by writing ones into the detect register. A handler normally reads the detect register to find the source, acknowledges it, and returns.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0, every detect flag is 0, every sense field reads 0x02 (high level) and every interrupt output is low.
- R2: A write to offset 0x08 enables each line whose data bit is 1 and leaves the lines written with 0 unchanged. A read of offset 0x04 returns the enable mask, with bit n for line n.
- R3: A write to offset 0x04 disables each line whose data bit is 1 and leaves the others unchanged.
- R4: Interrupt output n equals detect flag n AND enable n, in every cycle. A read of offset 0x00 returns the detect flags AND the enable mask.
- R5: With sense 0x02 (high level), the detect flag is 1 exactly when the synchronised input is high. The flag changes on the third clock edge after the input changes. A write-1 acknowledge has no lasting effect.
- R6: With sense 0x01 (low level), the detect flag is 1 exactly when the synchronised input is low, with the same latency as R5.
- R7: With sense 0x08 (rising edge), a low-to-high transition of the synchronised input sets the detect flag. The flag stays set until a 1 is written to its bit at offset 0x100.
- R8: With sense 0x04 (falling edge), a high-to-low transition sets the detect flag. It stays set until acknowledged as in R7.
- R9: With sense 0x0C (both edges), either transition sets the detect flag. It stays set until acknowledged as in R7.
- R10: A read of offset 0x100 returns all detect flags. Writing 0 to a bit of 0x100 leaves that flag unchanged.
- R11: The sense field of line n is bits [5:0] of the register at 0x180 + 4*n and reads back as written. Any code other than 0x01, 0x02, 0x04, 0x08 or 0x0C detects nothing and holds the flag at 0.
- R12: Read data appears on the clock edge that samples the read strobe and holds until the next read. Offset 0x08 and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_CH (32) | Asynchronous external interrupt lines |
| irq_out | output | NUM_CH (32) | Per-line interrupt requests towards the CPU |

## Verification
Interrupt outputs are compared against a reference model on every cycle. A wrong enable bit, a lost edge or a flag that clears by itself therefore shows at the ports within the same cycle it goes wrong, or at most three edges after the input moved. Wrong sense decoding shows as a flag that does not follow a level, or does not latch an edge, in a read of the detect register. A wrong synchroniser depth shifts the R5 latency by a cycle, which the per-cycle output comparison reports at once. Random line activity runs against random enable, acknowledge and sense writes, so acknowledges that coincide with new edges are also exercised.

// File: rtl/eic_pkg.sv
package eic_pkg;

   localparam int unsigned BUS_W = 32;

   typedef logic [5:0] sense_t;

   localparam sense_t SENSE_LVL_LO = 6'h01;
   localparam sense_t SENSE_LVL_HI = 6'h02;
   localparam sense_t SENSE_FALL   = 6'h04;
   localparam sense_t SENSE_RISE   = 6'h08;
   localparam sense_t SENSE_BOTH   = 6'h0C;

   localparam int unsigned OFF_PEND    = 32'h000;
   localparam int unsigned OFF_ENA     = 32'h004;
   localparam int unsigned OFF_ENA_SET = 32'h008;
   localparam int unsigned OFF_DET     = 32'h100;
   localparam int unsigned OFF_CFG     = 32'h180;

   typedef enum logic [2:0] {
      DM_NONE,
      DM_LO,
      DM_HI,
      DM_FALL,
      DM_RISE,
      DM_BOTH
   } det_mode_e;

   function automatic det_mode_e decode_sense(input sense_t s);
      det_mode_e m;
      case (s)
         SENSE_LVL_LO: m = DM_LO;
         SENSE_LVL_HI: m = DM_HI;
         SENSE_FALL:   m = DM_FALL;
         SENSE_RISE:   m = DM_RISE;
         SENSE_BOTH:   m = DM_BOTH;
         default:      m = DM_NONE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("eic_sync: STAGES must be at least 2");
      end

      if (STAGES == 2) begin : g_two
         logic [W-1:0] meta_q;
         logic [W-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q <= '0;
               sync_q <= '0;
            end else begin
               meta_q <= d_i;
               sync_q <= meta_q;
            end
         end
         assign q_o = sync_q;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q <= {pipe_q[STAGES-2:0], d_i};
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eic_chan.sv
module eic_chan
   import eic_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   samp_i,
   input  sense_t sense_i,
   input  logic   clr_i,
   output logic   det_o
);

   logic      prev_q;
   logic      det_q;
   logic      rise;
   logic      fall;
   logic      hit;
   logic      edge_mode;
   det_mode_e mode;

   always_comb begin
      mode = decode_sense(sense_i);
      rise = samp_i & ~prev_q;
      fall = ~samp_i & prev_q;
      edge_mode = (mode == DM_FALL) || (mode == DM_RISE) || (mode == DM_BOTH);
      case (mode)
         DM_LO:   hit = ~samp_i;
         DM_HI:   hit = samp_i;
         DM_FALL: hit = fall;
         DM_RISE: hit = rise;
         DM_BOTH: hit = rise | fall;
         default: hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         det_q  <= 1'b0;
      end else begin
         prev_q <= samp_i;
         det_q  <= hit | (det_q & edge_mode & ~clr_i);
      end
   end

   assign det_o = det_q;

   assert_level_hi_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i == SENSE_LVL_HI && samp_i) |=> det_o);

   assert_level_hi_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i == SENSE_LVL_HI && !samp_i) |=> !det_o);

   assert_level_lo_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i == SENSE_LVL_LO && !samp_i) |=> det_o);

   assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (det_o && (sense_i == SENSE_RISE || sense_i == SENSE_FALL ||
                 sense_i == SENSE_BOTH) && !clr_i) |=> det_o);

   assert_rise_catch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((sense_i == SENSE_RISE || sense_i == SENSE_BOTH) && $rose(samp_i)) |=> det_o);

   assert_fall_catch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((sense_i == SENSE_FALL || sense_i == SENSE_BOTH) && $fell(samp_i)) |=> det_o);

   assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i != SENSE_LVL_LO && sense_i != SENSE_LVL_HI && sense_i != SENSE_FALL &&
       sense_i != SENSE_RISE && sense_i != SENSE_BOTH) |=> !det_o);

endmodule

// File: rtl/eic_regs.sv
module eic_regs
   import eic_pkg::*;
#(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wen,
   input  logic [BUS_W-1:0]         bus_wdata,
   input  logic                     bus_ren,
   output logic [BUS_W-1:0]         bus_rdata,
   input  logic [NUM_CH-1:0]        det_i,
   output logic [NUM_CH-1:0]        en_o,
   output logic [NUM_CH-1:0][5:0]   sense_o,
   output logic [NUM_CH-1:0]        clr_o
);

   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFF_PEND);
   localparam logic [ADDR_W-1:0] A_ENA     = ADDR_W'(OFF_ENA);
   localparam logic [ADDR_W-1:0] A_ENA_SET = ADDR_W'(OFF_ENA_SET);
   localparam logic [ADDR_W-1:0] A_DET     = ADDR_W'(OFF_DET);
   localparam logic [ADDR_W-1:0] A_CFG     = ADDR_W'(OFF_CFG);
   localparam logic [ADDR_W-1:0] A_CFG_END = ADDR_W'(OFF_CFG + 4 * NUM_CH);

   logic [NUM_CH-1:0]      en_q;
   logic [NUM_CH-1:0][5:0] sense_q;
   logic [BUS_W-1:0]       rdata_q;
   logic [BUS_W-1:0]       rd_mux;
   logic [NUM_CH-1:0]      wmask;
   logic                   cfg_hit;
   logic [IDX_W-1:0]       cfg_idx;
   logic                   wr_set;
   logic                   wr_clr;
   logic                   wr_det;

   always_comb begin
      wmask   = bus_wdata[NUM_CH-1:0];
      cfg_hit = (bus_addr >= A_CFG) && (bus_addr < A_CFG_END) && (bus_addr[1:0] == 2'b00);
      cfg_idx = bus_addr[IDX_W+1:2];
      wr_set  = bus_wen && (bus_addr == A_ENA_SET);
      wr_clr  = bus_wen && (bus_addr == A_ENA);
      wr_det  = bus_wen && (bus_addr == A_DET);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_set) begin
         en_q <= en_q | wmask;
      end else if (wr_clr) begin
         en_q <= en_q & ~wmask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) begin
            sense_q[i] <= SENSE_LVL_HI;
         end
      end else if (bus_wen && cfg_hit) begin
         sense_q[cfg_idx] <= bus_wdata[5:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr == A_PEND) begin
         rd_mux[NUM_CH-1:0] = det_i & en_q;
      end else if (bus_addr == A_ENA) begin
         rd_mux[NUM_CH-1:0] = en_q;
      end else if (bus_addr == A_DET) begin
         rd_mux[NUM_CH-1:0] = det_i;
      end else if (cfg_hit) begin
         rd_mux[5:0] = sense_q[cfg_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_ren) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = rdata_q;
   assign en_o      = en_q;
   assign sense_o   = sense_q;
   assign clr_o     = wr_det ? wmask : '0;

   assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en_o & $past(wmask)) == $past(wmask)));

   assert_en_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en_o & ~$past(wmask)) == ($past(en_o) & ~$past(wmask))));

   assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((en_o & $past(wmask)) == '0));

   assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ren |=> $stable(bus_rdata));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import eic_pkg::*;
#(
   parameter int unsigned NUM_CH      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_ren,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_CH-1:0] irq_in,
   output logic [NUM_CH-1:0] irq_out
);

   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
         $error("ext_irq_ctrl: NUM_CH must lie in 1..32");
      end
      if (ADDR_W < 10) begin : g_bad_aw
         $error("ext_irq_ctrl: ADDR_W too small for the configuration window");
      end
   endgenerate

   logic [NUM_CH-1:0]      samp;
   logic [NUM_CH-1:0]      det;
   logic [NUM_CH-1:0]      en;
   logic [NUM_CH-1:0]      clr;
   logic [NUM_CH-1:0][5:0] sense;

   eic_sync #(
      .W      (NUM_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (irq_in),
      .q_o   (samp)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
         eic_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .samp_i  (samp[g]),
            .sense_i (sense[g]),
            .clr_i   (clr[g]),
            .det_o   (det[g])
         );
      end
   endgenerate

   eic_regs #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wen   (bus_wen),
      .bus_wdata (bus_wdata),
      .bus_ren   (bus_ren),
      .bus_rdata (bus_rdata),
      .det_i     (det),
      .en_o      (en),
      .sense_o   (sense),
      .clr_o     (clr)
   );

   assign irq_out = det & en;

   assert_out_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out[0]) |-> (en[0] && $past(en[0] | bus_wen) && det[0]));

endmodule

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;

   localparam int NCH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ren = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_in = '0;
   logic [31:0] irq_out;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   ext_irq_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wen   (bus_wen),
      .bus_wdata (bus_wdata),
      .bus_ren   (bus_ren),
      .bus_rdata (bus_rdata),
      .irq_in    (irq_in),
      .irq_out   (irq_out)
   );

   // reference model built from the requirements
   logic [31:0] m_s1, m_s2, m_prev, m_det, m_en, m_rd;
   logic [5:0]  m_sense [NCH];

   function automatic logic [31:0] model_read(input logic [11:0] a);
      logic [31:0] r;
      r = '0;
      if (a == 12'h000) r = m_det & m_en;
      else if (a == 12'h004) r = m_en;
      else if (a == 12'h100) r = m_det;
      else if (a >= 12'h180 && a < 12'h200 && a[1:0] == 2'b00) r = {26'b0, m_sense[a[6:2]]};
      return r;
   endfunction

   always @(posedge clk) begin
      logic [31:0] nd;
      logic [31:0] clr;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_det = '0; m_en = '0; m_rd = '0;
         for (int i = 0; i < NCH; i++) m_sense[i] = 6'h02;
      end else begin
         if (bus_ren) m_rd = model_read(bus_addr);
         clr = (bus_wen && bus_addr == 12'h100) ? bus_wdata : '0;
         for (int i = 0; i < NCH; i++) begin
            logic [5:0] sn;
            logic r, f, lvl, ed;
            sn  = m_sense[i];
            r   = m_s2[i] & ~m_prev[i];
            f   = ~m_s2[i] & m_prev[i];
            lvl = (sn == 6'h01 && !m_s2[i]) || (sn == 6'h02 && m_s2[i]);
            ed  = (sn == 6'h04 || sn == 6'h08 || sn == 6'h0C);
            nd[i] = lvl || (r && (sn == 6'h08 || sn == 6'h0C)) ||
                    (f && (sn == 6'h04 || sn == 6'h0C)) || (m_det[i] && ed && !clr[i]);
         end
         m_det  = nd;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = irq_in;
         if (bus_wen && bus_addr == 12'h008) m_en = m_en | bus_wdata;
         if (bus_wen && bus_addr == 12'h004) m_en = m_en & ~bus_wdata;
         if (bus_wen && bus_addr >= 12'h180 && bus_addr < 12'h200 && bus_addr[1:0] == 2'b00)
            m_sense[bus_addr[6:2]] = bus_wdata[5:0];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // every cycle: R4 output gating against the model
   task automatic step();
      @(negedge clk);
      chk("R4 irq_out", irq_out, m_det & m_en);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      step();
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      bus_addr = a; bus_ren = 1'b1;
      step();
      bus_ren = 1'b0;
      chk(tag, bus_rdata, m_rd);
   endtask

   function automatic string tag_of(input logic [11:0] a);
      if (a == 12'h000) return "R4 pending read";
      if (a == 12'h004) return "R2 enable read";
      if (a == 12'h100) return "R10 detect read";
      if (a >= 12'h180 && a < 12'h200) return "R11 sense read";
      return "R12 unmapped read";
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      chk("R1 irq_out after reset", irq_out, 32'h0);
      rd(12'h004, "R1 enable after reset");
      chk("R1 enable literal", bus_rdata, 32'h0);
      rd(12'h100, "R1 detect after reset");
      rd(12'h180, "R1 sense after reset");
      chk("R1 sense literal", bus_rdata, 32'h2);
      rd(12'h1FC, "R1 last sense after reset");

      // R2 / R3: enable set and clear
      wr(12'h008, 32'h0000_00FF);
      rd(12'h004, "R2 enable set");
      chk("R2 enable literal", bus_rdata, 32'h0000_00FF);
      wr(12'h008, 32'h0);
      rd(12'h004, "R2 zero bits keep enables");
      wr(12'h004, 32'h0000_000F);
      rd(12'h004, "R3 enable clear");
      chk("R3 enable literal", bus_rdata, 32'h0000_00F0);
      wr(12'h008, 32'hFFFF_FFFF);

      // R5: high level on line 0, acknowledge has no lasting effect
      irq_in[0] = 1'b1;
      idle(5);
      rd(12'h100, "R5 level high set");
      wr(12'h100, 32'h1);
      idle(2);
      rd(12'h100, "R5 acknowledge while level held");
      chk("R5 flag literal", bus_rdata & 32'h1, 32'h1);
      irq_in[0] = 1'b0;
      idle(5);
      rd(12'h100, "R5 level released");

      // R6: low level on line 1
      wr(12'h184, 32'h01);
      idle(2);
      rd(12'h100, "R6 low level active");
      irq_in[1] = 1'b1;
      idle(5);
      rd(12'h100, "R6 low level released");

      // R7: rising edge on line 2
      wr(12'h188, 32'h08);
      irq_in[2] = 1'b1; idle(5);
      irq_in[2] = 1'b0; idle(5);
      rd(12'h100, "R7 rising latched");
      chk("R7 flag literal", bus_rdata & 32'h4, 32'h4);
      wr(12'h100, 32'h4);
      idle(1);
      rd(12'h100, "R7 acknowledged");

      // R8: falling edge on line 3
      wr(12'h18C, 32'h04);
      irq_in[3] = 1'b1; idle(5);
      rd(12'h100, "R8 no flag on rise");
      irq_in[3] = 1'b0; idle(5);
      rd(12'h100, "R8 falling latched");
      wr(12'h100, 32'h8);
      rd(12'h100, "R8 acknowledged");

      // R9: both edges on line 4
      wr(12'h190, 32'h0C);
      irq_in[4] = 1'b1; idle(5);
      rd(12'h100, "R9 rise latched");
      wr(12'h100, 32'h10);
      irq_in[4] = 1'b0; idle(5);
      rd(12'h100, "R9 fall latched");

      // R10: writing zeros leaves flags
      wr(12'h100, 32'h0);
      rd(12'h100, "R10 zero write keeps flags");
      rd(12'h000, "R4 pending masked");
      wr(12'h004, 32'h0000_0010);
      rd(12'h000, "R4 pending after disable");

      // R11: unknown code detects nothing, read-back of the field
      wr(12'h194, 32'hFFFF_FF3F);
      rd(12'h194, "R11 sense read-back");
      chk("R11 sense literal", bus_rdata, 32'h3F);
      irq_in[5] = 1'b1; idle(5);
      irq_in[5] = 1'b0; idle(5);
      rd(12'h100, "R11 unknown code silent");

      // R12: unmapped and set-register reads
      rd(12'h0FC, "R12 unmapped read");
      chk("R12 unmapped literal", bus_rdata, 32'h0);
      rd(12'h008, "R12 set register reads zero");
      idle(3);
      chk("R12 read data holds", bus_rdata, m_rd);

      // random phase
      for (int it = 0; it < 6000; it++) begin
         logic [11:0] a;
         logic [5:0]  code;
         irq_in = irq_in ^ ($urandom & $urandom & $urandom);
         case ($urandom % 8)
            0: wr(12'h008, $urandom & $urandom);
            1: wr(12'h004, $urandom & $urandom & $urandom);
            2: wr(12'h100, $urandom);
            3: begin
               case ($urandom % 8)
                  0: code = 6'h01; 1: code = 6'h02; 2: code = 6'h04;
                  3: code = 6'h08; 4, 5: code = 6'h0C; 6: code = 6'h00;
                  default: code = 6'($urandom);
               endcase
               wr(12'h180 + 12'(($urandom % NCH) * 4), {26'($urandom), code});
            end
            4, 5: begin
               case ($urandom % 6)
                  0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h100;
                  3: a = 12'h180 + 12'(($urandom % NCH) * 4);
                  4: a = 12'h008;
                  default: a = 12'($urandom) & 12'hFFC;
               endcase
               rd(a, tag_of(a));
            end
            default: step();
         endcase
      end
      finish_run();
   end

endmodule